// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Core

This core turns a set of already-decoded tuning and control values into a periodic digital waveform. On every clock a 28-bit phase accumulator adds one of two selectable frequency words. One of two selectable 12-bit phase offsets is added to the top 12 accumulator bits. The resulting phase is shaped into a sine, a triangle or a square sample. The core drives a 10-bit offset-binary sample bus and a single-bit square output.

Switching the frequency bank gives frequency-shift keying, and switching the phase bank gives phase-shift keying. A hold input parks the core at zero phase with a mid-scale output, so several cores released on the same clock stay phase-aligned. A pause input freezes everything in place. A sample-path disable parks the sample bus at mid-scale while the square output keeps running.

The output frequency is the frequency word times the clock rate divided by 2^28. At 25 MHz that is about 10.737 word counts per hertz.

Both outputs are produced on every clock and cannot be stalled, so the sample stream carries no valid/ready handshake and there is no back-pressure. A consumer that needs rate adaptation must buffer the stream itself. All control pins are plain levels that the core samples on the rising clock edge.

Top module: `dds_wave_core`

## Requirements
- R1: While `rst_n` is low, or `hold_zero` is high at a clock edge, the accumulator becomes 0, `sample` becomes 512 and the half-rate square flop becomes 0. After release, the accumulator after k further edges equals k times the selected word, modulo 2^28.
- R2: On each edge that is free of hold and pause, the accumulator advances by `freq_word1` when `fsel` is 1, and by `freq_word0` when `fsel` is 0, wrapping modulo 2^28. A change of `fsel` applies from the next edge.
- R3: The shaping phase is accumulator bits [27:16] plus `phase_ofs1` (`psel` = 1) or `phase_ofs0` (`psel` = 0), taken modulo 4096.
- R4: `sample` is registered. At each edge that is free of hold and pause, it takes the shaped value of the phase formed from the accumulator value before that edge.
- R5: Sine mode (`square_en` = 0, `tri_sel` = 0, `dac_off` = 0) works from phase p as follows:
  - a = p[9:2], replaced by 255 - a when p[10] = 1;
  - m = floor(511 * sin(pi * (2a + 1) / 1024) + 0.5);
  - the sample is 512 + m when p[11] = 0, and 511 - m when p[11] = 1.
- R6: Triangle mode (`tri_sel` = 1) gives p[10:1] when p[11] = 0 and 1023 - p[10:1] when p[11] = 1.
- R7: With `square_en` = 1 and `sq_direct` = 1, `sq_out` equals accumulator bit 27. The sample becomes 1023 when that bit was 1 before the edge and 0 when it was 0.
- R8: With `square_en` = 1 and `sq_direct` = 0, a flop toggles on each edge at which accumulator bit 27 is 1 after having been 0 at the previous active edge. `sq_out` and the full-scale sample follow that flop, giving half the direct rate.
- R9: With `square_en` = 0, `sq_out` is 0.
- R10: While `pause` is high (and `hold_zero` low), the accumulator, the sample and the half-rate flop keep their values. Clearing `pause` resumes from them.
- R11: With `dac_off` = 1, each active edge loads 512 into `sample`. `sq_out` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word0 | input | 28 | Frequency word, bank 0 |
| freq_word1 | input | 28 | Frequency word, bank 1 |
| phase_ofs0 | input | 12 | Phase offset, bank 0 |
| phase_ofs1 | input | 12 | Phase offset, bank 1 |
| fsel | input | 1 | Frequency bank select |
| psel | input | 1 | Phase bank select |
| hold_zero | input | 1 | Clear accumulator, park sample at mid-scale |
| pause | input | 1 | Freeze accumulator and outputs |
| dac_off | input | 1 | Park sample bus at mid-scale |
| square_en | input | 1 | Square mode select |
| sq_direct | input | 1 | 1: square from accumulator MSB, 0: half rate |
| tri_sel | input | 1 | 1: triangle, 0: sine (when not square) |
| sample | output | 10 | Offset-binary waveform sample |
| sq_out | output | 1 | Square output |

## Verification
The assertions assume that every control and tuning input is a synchronous level that is stable around the rising edge. They also assume that `rst_n` deasserts away from an edge, since the advance and freeze properties compare successive edge values. The bench drives every input only at the falling edge and releases reset there too. The bench keeps an arithmetic model of the accumulator and of the shaping formulas. A frequency word of 2^16 steps the phase by one per clock, so the sine and triangle sweeps cover all 4096 phases exhaustively.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic hold_zero;
    logic pause;
    logic dac_off;
    logic square_en;
    logic sq_direct;
    logic tri_sel;
  } dds_mode_t;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_zero,
  input  logic             pause,
  input  logic             fsel,
  input  logic             psel,
  input  logic [ACC_W-1:0] freq_word0,
  input  logic [ACC_W-1:0] freq_word1,
  input  logic [PH_W-1:0]  phase_ofs0,
  input  logic [PH_W-1:0]  phase_ofs1,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  phase
);
  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  ofs;

  // bank muxes feed the adder directly; a select change acts on the next edge
  assign step  = fsel ? freq_word1 : freq_word0;
  assign ofs   = psel ? phase_ofs1 : phase_ofs0;
  assign phase = acc_q[ACC_W-1 -: PH_W] + ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (hold_zero) begin
      acc_q <= '0;
    end else if (!pause) begin
      acc_q <= acc_q + step;
    end
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] sine_val
);
  localparam int QBITS  = PH_W - 2;
  localparam int DROP   = QBITS - LUT_AW;
  localparam int NENT   = 1 << LUT_AW;
  localparam int MAG_W  = OUT_W - 1;
  localparam int MAXMAG = (1 << MAG_W) - 1;
  localparam int MID    = 1 << MAG_W;

  function automatic logic [MAG_W-1:0] quarter_val(input int idx);
    real ang;
    ang = (real'(idx) + 0.5) * 3.141592653589793 / (2.0 * real'(NENT));
    return MAG_W'($rtoi(real'(MAXMAG) * $sin(ang) + 0.5));
  endfunction

  logic [MAG_W-1:0]  tbl [NENT];
  logic [LUT_AW-1:0] raw_addr;
  logic [LUT_AW-1:0] addr;
  logic [OUT_W-1:0]  mag_ext;

  for (genvar i = 0; i < NENT; i++) begin : g_tbl
    assign tbl[i] = quarter_val(i);
  end

  if (DROP > 0) begin : g_drop
    logic unused_lsb;
    assign unused_lsb = ^phase[DROP-1:0];
  end

  // second and fourth quarters read the table backwards
  assign raw_addr = phase[QBITS-1 -: LUT_AW];
  assign addr     = phase[PH_W-2] ? ~raw_addr : raw_addr;
  assign mag_ext  = {1'b0, tbl[addr]};
  // second half of the cycle mirrors below mid-scale
  assign sine_val = phase[PH_W-1] ? (OUT_W'(MID - 1) - mag_ext)
                                  : (OUT_W'(MID) + mag_ext);
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dds_mode_t        mode,
  input  logic             acc_msb,
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] sample,
  output logic             sq_out
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));
  localparam int TLSB = PH_W - 1 - OUT_W;

  logic [OUT_W-1:0] sine_val;
  logic [OUT_W-1:0] tri_val;
  logic [OUT_W-1:0] ramp;
  logic [OUT_W-1:0] shaped;
  logic [OUT_W-1:0] sample_q;
  logic             half_q;
  logic             prev_msb_q;
  logic             sq_bit;

  dds_sine_rom #(.PH_W(PH_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) sine_i (
    .phase    (phase),
    .sine_val (sine_val)
  );

  if (TLSB > 0) begin : g_tri_drop
    logic unused_tri;
    assign unused_tri = ^phase[TLSB-1:0];
  end

  // rising ramp over the first half of the cycle, inverted over the second
  assign ramp    = phase[PH_W-2 -: OUT_W];
  assign tri_val = phase[PH_W-1] ? ~ramp : ramp;
  assign sq_bit  = mode.sq_direct ? acc_msb : half_q;

  always_comb begin
    if (mode.dac_off)        shaped = MID;
    else if (mode.square_en) shaped = {OUT_W{sq_bit}};
    else if (mode.tri_sel)   shaped = tri_val;
    else                     shaped = sine_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q   <= MID;
      half_q     <= 1'b0;
      prev_msb_q <= 1'b0;
    end else if (mode.hold_zero) begin
      sample_q   <= MID;
      half_q     <= 1'b0;
      prev_msb_q <= 1'b0;
    end else if (!mode.pause) begin
      sample_q   <= shaped;
      prev_msb_q <= acc_msb;
      if (acc_msb && !prev_msb_q) half_q <= ~half_q;
    end
  end

  assign sample = sample_q;
  assign sq_out = mode.square_en & sq_bit;
endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core
  import dds_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word0,
  input  logic [ACC_W-1:0] freq_word1,
  input  logic [PH_W-1:0]  phase_ofs0,
  input  logic [PH_W-1:0]  phase_ofs1,
  input  logic             fsel,
  input  logic             psel,
  input  logic             hold_zero,
  input  logic             pause,
  input  logic             dac_off,
  input  logic             square_en,
  input  logic             sq_direct,
  input  logic             tri_sel,
  output logic [OUT_W-1:0] sample,
  output logic             sq_out
);
  dds_mode_t        mode;
  logic [ACC_W-1:0] acc_w;
  logic [PH_W-1:0]  phase_w;

  assign mode = '{hold_zero: hold_zero, pause: pause, dac_off: dac_off,
                  square_en: square_en, sq_direct: sq_direct, tri_sel: tri_sel};

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_zero  (hold_zero),
    .pause      (pause),
    .fsel       (fsel),
    .psel       (psel),
    .freq_word0 (freq_word0),
    .freq_word1 (freq_word1),
    .phase_ofs0 (phase_ofs0),
    .phase_ofs1 (phase_ofs1),
    .acc_q      (acc_w),
    .phase      (phase_w)
  );

  dds_shaper #(.PH_W(PH_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) shp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .acc_msb (acc_w[ACC_W-1]),
    .phase   (phase_w),
    .sample  (sample),
    .sq_out  (sq_out)
  );
endmodule

// File: rtl/dds_wave_core_chk.sv
module dds_wave_core_chk #(
  parameter int ACC_W = 28,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_zero,
  input logic             pause,
  input logic             dac_off,
  input logic             square_en,
  input logic             fsel,
  input logic [ACC_W-1:0] freq_word0,
  input logic [ACC_W-1:0] freq_word1,
  input logic [ACC_W-1:0] acc,
  input logic [OUT_W-1:0] sample,
  input logic             sq_out
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  // R1
  a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (acc == '0 && sample == MID));

  // R2
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_zero && !pause) |=>
      acc == $past(acc) + $past(fsel ? freq_word1 : freq_word0));

  // R10
  a_r10_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !hold_zero) |=> ($stable(acc) && $stable(sample)));

  // R11
  a_r11_dac_off_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_off && !hold_zero && !pause) |=> sample == MID);

  // R7
  a_r7_square_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (square_en && !dac_off && !hold_zero && !pause) |=>
      (sample == '0 || sample == {OUT_W{1'b1}}));

  // R9
  a_r9_square_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !square_en |-> !sq_out);
endmodule

bind dds_wave_core dds_wave_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_zero  (hold_zero),
  .pause      (pause),
  .dac_off    (dac_off),
  .square_en  (square_en),
  .fsel       (fsel),
  .freq_word0 (freq_word0),
  .freq_word1 (freq_word1),
  .acc        (acc_w),
  .sample     (sample),
  .sq_out     (sq_out)
);

// File: tb/dds_wave_core_tb_top.sv
`timescale 1ns/1ps
module dds_wave_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] freq_word0 = '0, freq_word1 = '0;
  logic [11:0] phase_ofs0 = '0, phase_ofs1 = '0;
  logic        fsel = 0, psel = 0, hold_zero = 0, pause = 0;
  logic        dac_off = 0, square_en = 0, sq_direct = 0, tri_sel = 0;
  logic [9:0]  sample;
  logic        sq_out;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dds_wave_core dut_i (
    .clk(clk), .rst_n(rst_n), .freq_word0(freq_word0), .freq_word1(freq_word1),
    .phase_ofs0(phase_ofs0), .phase_ofs1(phase_ofs1), .fsel(fsel), .psel(psel),
    .hold_zero(hold_zero), .pause(pause), .dac_off(dac_off), .square_en(square_en),
    .sq_direct(sq_direct), .tri_sel(tri_sel), .sample(sample), .sq_out(sq_out)
  );

  // expected values taken straight from the requirement formulas
  function automatic int sine_ref(input logic [11:0] p);
    int a, m;
    a = int'(p[9:2]);
    if (p[10]) a = 255 - a;
    m = $rtoi(511.0 * $sin(3.141592653589793 * real'(2 * a + 1) / 1024.0) + 0.5);
    return p[11] ? 511 - m : 512 + m;
  endfunction

  function automatic int tri_ref(input logic [11:0] p);
    int v;
    v = int'(p[10:1]);
    return p[11] ? 1023 - v : v;
  endfunction

  // reference state, advanced once per rising edge
  logic [27:0] m_acc;
  logic        m_prev, m_half;
  int          m_sample;

  always @(posedge clk or negedge rst_n) begin
    logic [11:0] ph;
    logic        sb;
    if (!rst_n || hold_zero) begin
      m_acc = '0; m_prev = 0; m_half = 0; m_sample = 512;
    end else if (!pause) begin
      ph = m_acc[27:16] + (psel ? phase_ofs1 : phase_ofs0);
      sb = sq_direct ? m_acc[27] : m_half;
      if (dac_off)        m_sample = 512;
      else if (square_en) m_sample = sb ? 1023 : 0;
      else if (tri_sel)   m_sample = tri_ref(ph);
      else                m_sample = sine_ref(ph);
      if (m_acc[27] && !m_prev) m_half = !m_half;
      m_prev = m_acc[27];
      m_acc  = m_acc + (fsel ? freq_word1 : freq_word0);
    end
  end

  task automatic check_now(input string tag);
    int exp_sq;
    exp_sq = square_en ? int'(sq_direct ? m_acc[27] : m_half) : 0;
    n_checks++;
    if (int'(sample) != m_sample) begin
      n_bad++;
      $display("FAIL %s sample actual=%0d expected=%0d", tag, sample, m_sample);
    end
    n_checks++;
    if (int'(sq_out) != exp_sq) begin
      n_bad++;
      $display("FAIL %s sq_out actual=%0d expected=%0d", tag, sq_out, exp_sq);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now(tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1 reset state");
    rst_n = 1; hold_zero = 1;
    run(3, "R1 hold");
    freq_word0 = 28'h0010000;
    hold_zero = 0;
    run(4100, "R5 sine sweep");
    tri_sel = 1;
    run(4100, "R6 triangle sweep");
    tri_sel = 0; psel = 1; phase_ofs1 = 12'h5A3; phase_ofs0 = 12'h0FF;
    run(600, "R3 phase bank 1");
    for (int k = 0; k < 20; k++) begin
      psel = ~psel;
      run(11, "R3 PSK toggling");
    end
    fsel = 1; freq_word1 = 28'h0123457;
    run(1500, "R2 frequency bank 1");
    for (int k = 0; k < 40; k++) begin
      fsel = ~fsel;
      run(7, "R2 FSK toggling");
    end
    pause = 1;
    run(50, "R10 paused");
    pause = 0;
    run(50, "R10 resumed");
    fsel = 0; freq_word0 = 28'h0400000; square_en = 1; sq_direct = 1;
    run(400, "R7 direct square");
    sq_direct = 0;
    run(800, "R8 half-rate square");
    pause = 1;
    run(20, "R10 paused square");
    pause = 0;
    dac_off = 1;
    run(200, "R11 sample path off, square running");
    square_en = 0; tri_sel = 1;
    run(100, "R9 square idle, R11 still mid");
    dac_off = 0;
    run(100, "R4 triangle after sample path on");
    hold_zero = 1;
    run(5, "R1 hold mid-run");
    hold_zero = 0; tri_sel = 0;
    run(200, "R1 restart from zero");
    freq_word0 = 28'hFFFFFFF;
    run(300, "R2 wrap near full scale");
    rst_n = 0;
    run(2, "R1 async reset");
    rst_n = 1;
    run(100, "R4 after reset");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule